// File: doc/BRIEF.md
# Table-Driven Registered Moore Machine

This block runs any Moore finite state machine that fits its configured size, without changing the hardware. Its next-state function lives in a small synchronous memory rather than in gates. The current state code and the incoming input symbol are concatenated into the memory address, and the registered word read back becomes the new current state. A second table, indexed by the state alone, gives the output word. That word is captured in a register on the same edge as the state it belongs to.

Both tables are loaded at run time through a simple write port. Loading is only accepted while the machine is held in reset, so a lookup never meets a write to the same table. A typical use is to hold reset low, load the transition and output tables, keep reset low for one more cycle so the output register picks up the new entry for state 0, and then release reset. From then on the machine steps on each cycle that has the clock enable high.

Top module: `tmm_machine`

## Requirements
- R1: While `rst_n` is low at a rising edge, the state returns to code 0 and `out_word` takes the output-table entry for state 0 as it stands at that edge.
- R2: On a rising edge with `rst_n` high and `en` high, the new state is the next-state table word at address {current state, `sym_in`}, with the state code in the high bits and the symbol in the low `IN_BITS` bits.
- R3: The output depends only on the state. After every stepping edge, `out_word` equals the output-table entry of the state entered on that edge, whatever the symbol.
- R4: On an edge with `rst_n` high and `en` low, both the state and `out_word` keep their values.
- R5: While `rst_n` is low, `wr_en` high with `wr_sel`=0 writes `wr_data[SW-1:0]` to next-state entry `wr_addr`. With `wr_sel`=1 it writes `wr_data[OUT_BITS-1:0]` to the output entry of state `wr_addr[AW-1:IN_BITS]`, so state s is written at address s shifted left by `IN_BITS`.
- R6: A write request made while `rst_n` is high changes neither table.
- R7: A state code at or above `NUM_STATES` whose table rows are loaded to return to 0 leaves after one stepping edge, and its own output entry is seen for that one cycle.
- R8: With a serial 1011 detector loaded, the output flags each match, including matches that overlap through the trailing 1.
- R9: Loading a different pair of tables during a later reset makes the same hardware run the new machine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; also opens the write port |
| en | input | 1 | Clock enable for stepping the machine |
| sym_in | input | IN_BITS | Input symbol, 0 to 2^IN_BITS-1 |
| out_word | output | OUT_BITS | Registered Moore output |
| wr_en | input | 1 | Table write request |
| wr_sel | input | 1 | 0 selects the next-state table, 1 the output table |
| wr_addr | input | SW+IN_BITS | Table address, {state, symbol} layout |
| wr_data | input | max(SW,OUT_BITS) | Table write data |

## Verification
The bench builds the block with five states, one input bit and a two-bit output. That gives a three-bit state code, so codes 5 to 7 exist but are not used. A 16-word next-state table and an 8-entry output table can then be loaded in full in a few dozen cycles. Because the unused codes exist, an illegal-state excursion can be reached through a reloaded table and watched at the output. The 1011 detector exercises overlapping matches. A second, counter-like machine loaded later confirms a run-time reload, and a blocked write attempted during operation targets the detector's match entry, where any leak would be visible.

// File: rtl/tmm_pkg.sv
// Shared definitions for the table-driven Moore machine.
// Assumes: nothing beyond IEEE 1800-2017.
package tmm_pkg;

    // Which table a write request targets.
    typedef enum logic {
        TBL_NEXT = 1'b0,
        TBL_OUT  = 1'b1
    } tbl_sel_e;

    // Code width for a given state count, never below one bit.
    function automatic int code_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tmm_wr_gate.sv
// Write gate: turns a write request into per-table write strobes.
// Assumes: writes are legal only while the machine sits in reset, so a
// request arriving with rst_n high is dropped here.
module tmm_wr_gate
    import tmm_pkg::*;
(
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_sel,
    output logic ns_we,
    output logic out_we
);

    logic allowed;

    // Decode the request into one strobe per table, only during reset.
    always_comb begin
        allowed = wr_en && !rst_n;
        ns_we   = allowed && (tbl_sel_e'(wr_sel) == TBL_NEXT);
        out_we  = allowed && (tbl_sel_e'(wr_sel) == TBL_OUT);
    end

endmodule

// File: rtl/tmm_next_table.sv
// Next-state memory and state register.
// The registered lookup of {state, symbol} is itself the current state.
// Assumes: the strobe 'we' is only raised while rst_n is low.
module tmm_next_table #(
    parameter int SW = 3,
    parameter int IW = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IW-1:0]    sym,
    input  logic             we,
    input  logic [SW+IW-1:0] waddr,
    input  logic [SW-1:0]    wdata,
    output logic [SW-1:0]    state_q,
    output logic [SW-1:0]    state_d
);

    localparam int AW    = SW + IW;
    localparam int DEPTH = 1 << AW;

    logic [SW-1:0] ns_mem [DEPTH];
    logic [AW-1:0] rd_addr;

    // Form the lookup address from the current state and the symbol.
    always_comb begin
        rd_addr = {state_q, sym};
        state_d = ns_mem[rd_addr];
    end

    // Table load port.
    always_ff @(posedge clk) begin
        if (we) begin
            ns_mem[waddr] <= wdata;
        end
    end

    // State register: the registered table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (en) begin
            state_q <= state_d;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> state_q == '0);

    assert_hold_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_q));

    assert_no_run_write_R6: assert property (@(posedge clk)
        we |-> !rst_n);

endmodule

// File: rtl/tmm_out_table.sv
// Output table and registered output.
// The output register loads the entry of the state that the state register
// enters on the same edge, so output and state always agree.
// Assumes: 'we' only while rst_n is low; chk_* is a read-only side port.
module tmm_out_table #(
    parameter int SW = 3,
    parameter int OW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [SW-1:0] state_d,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [OW-1:0] wdata,
    input  logic [SW-1:0] chk_addr,
    output logic [OW-1:0] chk_data,
    output logic [OW-1:0] out_q
);

    localparam int DEPTH = 1 << SW;

    logic [OW-1:0] out_mem [DEPTH];

    // Side read used to compare the output against the current state.
    always_comb begin
        chk_data = out_mem[chk_addr];
    end

    // Table load port.
    always_ff @(posedge clk) begin
        if (we) begin
            out_mem[waddr] <= wdata;
        end
    end

    // Output register: entry of state 0 in reset, else of the entered state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= out_mem[0];
        end else if (en) begin
            out_q <= out_mem[state_d];
        end
    end

    assert_hold_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(out_q));

endmodule

// File: rtl/tmm_machine.sv
// Top of the table-driven registered Moore machine.
// Joins the write gate, the next-state memory and the output table.
// Assumes: tables are loaded during reset, and reset is held one cycle past
// the last write so the output register sees the new entry for state 0.
module tmm_machine
    import tmm_pkg::*;
#(
    parameter int NUM_STATES = 5,
    parameter int IN_BITS    = 1,
    parameter int OUT_BITS   = 2,
    localparam int SW        = code_width(NUM_STATES),
    localparam int AW        = SW + IN_BITS,
    localparam int DW        = (SW > OUT_BITS) ? SW : OUT_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [IN_BITS-1:0]  sym_in,
    output logic [OUT_BITS-1:0] out_word,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data
);

    logic                ns_we;
    logic                out_we;
    logic [SW-1:0]       state_q;
    logic [SW-1:0]       state_d;
    logic [OUT_BITS-1:0] chk_data;
    logic [OUT_BITS-1:0] out_q;

    tmm_wr_gate u_gate (
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .ns_we  (ns_we),
        .out_we (out_we)
    );

    tmm_next_table #(.SW(SW), .IW(IN_BITS)) u_next (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .sym     (sym_in),
        .we      (ns_we),
        .waddr   (wr_addr),
        .wdata   (wr_data[SW-1:0]),
        .state_q (state_q),
        .state_d (state_d)
    );

    tmm_out_table #(.SW(SW), .OW(OUT_BITS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .state_d  (state_d),
        .we       (out_we),
        .waddr    (wr_addr[AW-1:IN_BITS]),
        .wdata    (wr_data[OUT_BITS-1:0]),
        .chk_addr (state_q),
        .chk_data (chk_data),
        .out_q    (out_q)
    );

    // Drive the output port from the output register.
    always_comb begin
        out_word = out_q;
    end

    assert_out_matches_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_q == chk_data);

    assert_one_table_R5: assert property (@(posedge clk)
        $onehot0({ns_we, out_we}));

endmodule

// File: tb/sim_tmm_machine.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor pops them.
module sim_tmm_machine;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 5;
    localparam int IB = 1;
    localparam int OB = 2;
    localparam int K  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [IB-1:0] sym_in = '0;
    logic [OB-1:0] out_word;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [K:0]    wr_addr = '0;
    logic [K-1:0]  wr_data = '0;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [K-1:0]  f_tab [16];
    logic [OB-1:0] o_tab [8];
    logic [K-1:0]  mstate = '0;

    logic [OB-1:0] exp_q [$];
    string         tag_q [$];

    tmm_machine #(.NUM_STATES(NS), .IN_BITS(IB), .OUT_BITS(OB)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .sym_in(sym_in),
        .out_word(out_word), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare each result against the oldest expected item.
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            logic [OB-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (out_word !== e) begin
                bad++;
                $display("FAIL %s: out_word=%0d expected=%0d", t, out_word, e);
            end
        end
    end

    // Build the 1011 detector tables (R8).
    task automatic fill_detector();
        for (int s = 0; s < 8; s++) begin
            for (int b = 0; b < 2; b++) begin
                logic [K-1:0] n;
                case (s)
                    0: n = b ? 3'd1 : 3'd0;
                    1: n = b ? 3'd1 : 3'd2;
                    2: n = b ? 3'd3 : 3'd0;
                    3: n = b ? 3'd4 : 3'd2;
                    4: n = b ? 3'd1 : 3'd2;
                    default: n = 3'd0;
                endcase
                f_tab[s*2+b] = n;
            end
            o_tab[s] = (s == 0) ? 2'd2 : (s == 4) ? 2'd1 : (s >= NS) ? 2'd3 : 2'd0;
        end
    endtask

    // Build a counter machine whose top state escapes to illegal code 6 (R7, R9).
    task automatic fill_counter();
        for (int s = 0; s < 8; s++) begin
            f_tab[s*2]   = (s < NS) ? 3'(s) : 3'd0;
            f_tab[s*2+1] = (s < 4) ? 3'(s + 1) : (s == 4) ? 3'd6 : 3'd0;
            case (s)
                0: o_tab[s] = 2'd1;
                1: o_tab[s] = 2'd2;
                2: o_tab[s] = 2'd0;
                3: o_tab[s] = 2'd2;
                4: o_tab[s] = 2'd0;
                default: o_tab[s] = 2'd3;
            endcase
        end
    endtask

    // Write both model tables into the design while reset is low (R5).
    task automatic load_tables();
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            rst_n = 1'b0; en = 1'b0;
            wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 4'(a); wr_data = f_tab[a];
        end
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 1'b1; wr_addr = {3'(s), 1'b0}; wr_data = {1'b0, o_tab[s]};
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One reset cycle; output must show the state-0 entry (R1).
    task automatic rst_cycle(input string tag);
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; wr_en = 1'b0;
        mstate = '0;
        exp_q.push_back(o_tab[0]);
        tag_q.push_back(tag);
    endtask

    // One running cycle; 'w' raises a blocked write to state 4's output entry.
    task automatic step(input logic b, input logic e_v, input logic w, input string tag);
        @(negedge clk);
        rst_n = 1'b1; en = e_v; sym_in = b;
        wr_en = w; wr_sel = 1'b1; wr_addr = {3'd4, 1'b0}; wr_data = 3'd0;
        if (e_v) mstate = f_tab[{mstate, b}];
        exp_q.push_back(o_tab[mstate]);
        tag_q.push_back(tag);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        fill_detector();
        load_tables();
        rst_cycle("R1 reset output");
        rst_cycle("R1 reset held");
        // R2 R3 R8: overlapping 1011 matches
        step(1, 1, 0, "R2 step"); step(0, 1, 0, "R2 step");
        step(1, 1, 0, "R3 step"); step(1, 1, 0, "R8 first match");
        step(0, 1, 0, "R8 after match"); step(1, 1, 0, "R3 step");
        step(1, 1, 0, "R8 overlap match"); step(1, 1, 0, "R2 step");
        step(0, 1, 0, "R2 step"); step(1, 1, 0, "R3 step");
        step(1, 1, 0, "R8 third match");
        // R4: enable low holds the match flag
        step(0, 0, 0, "R4 hold"); step(1, 0, 0, "R4 hold");
        step(0, 0, 0, "R4 hold");
        // R6: write to state 4 output while running must be dropped
        step(0, 1, 1, "R6 write blocked"); step(1, 1, 1, "R6 write blocked");
        step(0, 1, 1, "R6 write blocked"); step(1, 1, 0, "R6 step");
        step(1, 1, 0, "R6 match intact");
        // R1 mid-run reset
        rst_cycle("R1 mid-run reset");
        // R9 R5: reload a different machine
        fill_counter();
        load_tables();
        rst_cycle("R9 reload reset");
        rst_cycle("R5 new state0 entry");
        step(1, 1, 0, "R9 count"); step(0, 1, 0, "R9 idle");
        step(1, 1, 0, "R5 count"); step(1, 1, 0, "R9 count");
        step(1, 1, 0, "R9 count");
        step(1, 1, 0, "R7 illegal entered");
        step(0, 1, 0, "R7 recovered");
        step(1, 1, 0, "R7 runs again");
        repeat (3) @(posedge clk);
        #3;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog: out_word=%0d expected=done", out_word);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule